// File: doc/BRIEF.md
# Carry-Save Montgomery Modular Multiplier

This block computes the Montgomery product X·Y·2^-K mod M for K-bit operands, one bit of X per clock. Its accumulator is never resolved during the computation. It is held as a redundant pair of registers, a sum word and a carry word, and each step goes through two rows of full adders without carry propagation. The same registers are reached through a 16-bit word port. A 2-bit mode field, given together with a command strobe, selects one of four operations: resolve the accumulator to binary, run a single reduction step, shift a word of operand data in, or shift a word of result data out.

In use, the host first loads X, Y and the odd modulus M through sixteen-bit load commands. It then pulses start, and the block runs all K reduction steps itself. The block resolves the accumulator with one wide addition, subtracts M once if needed, and raises done for one clock. The host then reads the result a word at a time. The host can also step the computation by hand with the single-step and resolve commands. Exponentiation sequencing, key handling and operand storage belong to the surrounding system.

Top module: `mont_cs_mul`

## Requirements
- R1: After an asynchronous active-low reset, busy, done and dout are all zero.
- R2: A load command (mode 2'b10) shifts the 3K-bit operand chain {M, Y, X} right by 16 bits and puts din into the top 16 bits. The host therefore loads X low word first, then Y, then M, in 3K/16 commands (12 for K=64).
- R3: A start pulse in an idle cycle clears the accumulator and runs K reduction steps, one per clock. Each step consumes the next bit of X, least significant first. The result is X·Y·2^-K mod M for an odd M and operands X, Y < M.
- R4: Every delivered result lies in the range 0 to M−1.
- R5: done is high for exactly one clock per completed result.
- R6: dout always shows the low 16 bits of the result register. An unload command (mode 2'b11) shifts the result right by 16 bits, so the host reads the result low word first.
- R7: A single-step command (mode 2'b01) performs exactly one reduction step with the current low bit of X. From a cleared accumulator, K such steps followed by a resolve command give the same result as a started run.
- R8: A resolve command (mode 2'b00) adds only the sum and carry words, then subtracts M once if the total is at least M. done is high after the second rising edge, counting the edge that samples the command. After start, done is high after the (K+3)th rising edge, counting the edge that samples start.
- R9: While busy is high, start and every command are ignored, and the operand chain does not change.
- R10: When start and a command arrive in the same idle cycle, start is taken and the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a full multiplication |
| cmd_valid | input | 1 | Command strobe for mode |
| mode | input | 2 | 00 resolve, 01 step, 10 load word, 11 unload word |
| din | input | 16 | Word data for load commands |
| dout | output | 16 | Low word of the result register |
| busy | output | 1 | A run or resolve is in progress |
| done | output | 1 | One-cycle pulse: result ready to unload |

## Verification
The bench drives inputs and samples outputs on falling edges. After a start is sampled, the bench counts falling edges and requires done to appear exactly K+3 of them later. After a resolve command it requires done two edges later, and on the edge after that it requires done low again. Load and unload commands take effect at the single rising edge that follows them, so each word of dout is read before the next unload command is issued. Every result is compared with a Montgomery product that the bench forms independently, by halving the plain product modulo M K times.

// File: rtl/mont_cs_pkg.sv
package mont_cs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CONV = 2'd2,
        ST_FIX  = 2'd3
    } mcs_state_e;

    typedef enum logic [1:0] {
        MD_RESOLVE = 2'b00,
        MD_STEP    = 2'b01,
        MD_LOAD    = 2'b10,
        MD_UNLOAD  = 2'b11
    } mcs_mode_e;
endpackage

// File: rtl/mcs_step.sv
// One radix-2 reduction step on a carry-save accumulator:
// add xbit*Y, add M when the low bit is odd, then halve.
module mcs_step #(
    parameter int AW = 66
) (
    input  logic [AW-1:0] s_in,
    input  logic [AW-1:0] c_in,
    input  logic [AW-1:0] y_ext,
    input  logic [AW-1:0] m_ext,
    input  logic          xbit,
    output logic [AW-1:0] s_out,
    output logic [AW-1:0] c_out
);
    logic [AW-1:0] a_add;
    logic [AW-1:0] b_add;
    logic [AW-1:0] s1, maj1, s2, maj2;
    logic [AW-1:0] c1, c2;
    logic          odd;

    assign a_add = xbit ? y_ext : '0;

    for (genvar i = 0; i < AW; i++) begin : g_row1
        assign s1[i]   = s_in[i] ^ c_in[i] ^ a_add[i];
        assign maj1[i] = (s_in[i] & c_in[i]) | (s_in[i] & a_add[i]) | (c_in[i] & a_add[i]);
    end
    assign c1 = {maj1[AW-2:0], 1'b0};

    assign odd   = s1[0];
    assign b_add = odd ? m_ext : '0;

    for (genvar i = 0; i < AW; i++) begin : g_row2
        assign s2[i]   = s1[i] ^ c1[i] ^ b_add[i];
        assign maj2[i] = (s1[i] & c1[i]) | (s1[i] & b_add[i]) | (c1[i] & b_add[i]);
    end
    assign c2 = {maj2[AW-2:0], 1'b0};

    assign s_out = {1'b0, s2[AW-1:1]};
    assign c_out = {1'b0, c2[AW-1:1]};
endmodule

// File: rtl/mcs_fix.sv
// Final correction: one conditional subtraction of the modulus.
module mcs_fix #(
    parameter int AW  = 66,
    parameter int OPW = 64
) (
    input  logic [AW-1:0]  val_in,
    input  logic [OPW-1:0] m_in,
    output logic [AW-1:0]  val_out
);
    localparam int PADW = AW - OPW;
    logic [AW-1:0] m_ext;
    logic [AW-1:0] diff;

    assign m_ext   = {{PADW{1'b0}}, m_in};
    assign diff    = val_in - m_ext;
    assign val_out = (val_in >= m_ext) ? diff : val_in;
endmodule

// File: rtl/mont_cs_mul.sv
module mont_cs_mul #(
    parameter int OPW   = 64,
    parameter int WORDW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmd_valid,
    input  logic [1:0]       mode,
    input  logic [WORDW-1:0] din,
    output logic [WORDW-1:0] dout,
    output logic             busy,
    output logic             done
);
    import mont_cs_pkg::*;

    localparam int AW   = OPW + 2;
    localparam int CHW  = 3 * OPW;
    localparam int CNTW = $clog2(OPW) + 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(OPW - 1);

    typedef struct packed {
        mcs_state_e     st;
        logic [CNTW-1:0] cnt;
        logic [AW-1:0]  s;
        logic [AW-1:0]  c;
        logic [CHW-1:0] chain;   // {M, Y, X}
        logic [AW-1:0]  res;
        logic           done;
    } mcs_regs_t;

    mcs_regs_t q, d;

    logic [OPW-1:0] x_view, y_view, m_view;
    logic [AW-1:0]  res_view;
    logic [AW-1:0]  step_s, step_c, fixed;
    logic [AW-1:0]  resolved;

    assign x_view   = q.chain[OPW-1:0];
    assign y_view   = q.chain[2*OPW-1:OPW];
    assign m_view   = q.chain[CHW-1:2*OPW];
    assign res_view = q.res;

    mcs_step #(.AW(AW)) u_step (
        .s_in  (q.s),
        .c_in  (q.c),
        .y_ext ({2'b00, y_view}),
        .m_ext ({2'b00, m_view}),
        .xbit  (x_view[0]),
        .s_out (step_s),
        .c_out (step_c)
    );

    mcs_fix #(.AW(AW), .OPW(OPW)) u_fix (
        .val_in  (q.res),
        .m_in    (m_view),
        .val_out (fixed)
    );

    assign resolved = q.s + q.c;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st  = ST_RUN;
                    d.s   = '0;
                    d.c   = '0;
                    d.cnt = '0;
                end else if (cmd_valid) begin
                    case (mcs_mode_e'(mode))
                        MD_RESOLVE: begin
                            d.res = resolved;
                            d.st  = ST_FIX;
                        end
                        MD_STEP: begin
                            d.s              = step_s;
                            d.c              = step_c;
                            d.chain[OPW-1:0] = {1'b0, x_view[OPW-1:1]};
                        end
                        MD_LOAD: begin
                            d.chain = {din, q.chain[CHW-1:WORDW]};
                        end
                        default: begin
                            d.res = q.res >> WORDW;
                        end
                    endcase
                end
            end
            ST_RUN: begin
                d.s              = step_s;
                d.c              = step_c;
                d.chain[OPW-1:0] = {1'b0, x_view[OPW-1:1]};
                d.cnt            = q.cnt + 1'b1;
                if (q.cnt == LAST) begin
                    d.st = ST_CONV;
                end
            end
            ST_CONV: begin
                d.res = resolved;
                d.st  = ST_FIX;
            end
            default: begin
                d.res  = fixed;
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dout = q.res[WORDW-1:0];
    assign busy = (q.st != ST_IDLE);
    assign done = q.done;
endmodule

// File: rtl/mont_cs_mul_chk.sv
module mont_cs_mul_chk #(
    parameter int OPW = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [OPW+1:0]   res_view,
    input logic [OPW-1:0]   m_view
);
    int unsigned bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt <= 0;
        end else if (busy) begin
            bcnt <= bcnt + 1;
        end else begin
            bcnt <= 0;
        end
    end

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_result_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_view < {2'b00, m_view}));

    assert_start_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_operands_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(m_view));

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bcnt == OPW + 2 || bcnt == 1));
endmodule

bind mont_cs_mul mont_cs_mul_chk #(.OPW(OPW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .res_view (res_view),
    .m_view   (m_view)
);

// File: tb/sim_mont_cs_mul.sv
`timescale 1ns/1ps
module sim_mont_cs_mul;
    localparam int K  = 64;
    localparam int WW = 16;
    localparam int NW = K / WW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [WW-1:0] din = '0;
    logic [WW-1:0] dout;
    logic          busy, done;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    mont_cs_mul #(.OPW(K), .WORDW(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cmd_valid),
        .mode(mode), .din(din), .dout(dout), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [K-1:0] act, input logic [K-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected product: (X*Y mod M) halved modulo M, K times.
    function automatic logic [K-1:0] ref_mont(input logic [K-1:0] x, input logic [K-1:0] y, input logic [K-1:0] m);
        logic [2*K-1:0] p;
        logic [K:0]     e;
        p = ({{K{1'b0}}, x} * {{K{1'b0}}, y}) % {{K{1'b0}}, m};
        e = {1'b0, p[K-1:0]};
        for (int i = 0; i < K; i++) begin
            if (e[0]) e = e + {1'b0, m};
            e = e >> 1;
        end
        return e[K-1:0];
    endfunction

    task automatic cmd(input logic [1:0] md, input logic [WW-1:0] w);
        cmd_valid = 1'b1;
        mode = md;
        din = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic load_ops(input logic [K-1:0] x, input logic [K-1:0] y, input logic [K-1:0] m);
        logic [3*K-1:0] all;
        all = {m, y, x};
        for (int i = 0; i < 3 * NW; i++) cmd(2'b10, all[i*WW +: WW]);
    endtask

    task automatic unload(output logic [K-1:0] r);
        for (int i = 0; i < NW; i++) begin
            r[i*WW +: WW] = dout;
            cmd(2'b11, '0);
        end
    endtask

    // variant: 0 plain, 1 command in same cycle as start (R10), 2 disturb while busy (R9)
    task automatic run_mul(input logic [K-1:0] x, input logic [K-1:0] y, input logic [K-1:0] m, input int variant);
        logic [K-1:0] r, e;
        int cyc;
        e = ref_mont(x, y, m);
        load_ops(x, y, m);
        start = 1'b1;
        if (variant == 1) begin
            cmd_valid = 1'b1; mode = 2'b10; din = 16'hA5A5;
        end
        @(negedge clk);
        start = 1'b0;
        cmd_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 400) begin
            if (variant == 2 && cyc == 10) begin
                start = 1'b1; cmd_valid = 1'b1; mode = 2'b10; din = 16'h5A5A;
            end
            @(negedge clk);
            start = 1'b0;
            cmd_valid = 1'b0;
            cyc++;
        end
        check(cyc == K + 3, variant == 2 ? "R9 latency with restart attempt" : "R8 start latency",
              K'(cyc), K'(K + 3));
        @(negedge clk);
        check(!done, "R5 done one cycle", K'(done), '0);
        unload(r);
        check(r < m, "R4 range", r, e);
        check(r == e, variant == 1 ? "R10 start wins" : (variant == 2 ? "R9 ignored while busy" : "R3 R2 R6 product"), r, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [K-1:0] x, y, m, r, e;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(!busy && !done && dout == 0, "R1 reset state", {busy, done, dout}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: manual stepping from the cleared accumulator
        m = 64'hF123_4567_89AB_CDEF;
        x = 64'h0123_4567_89AB_CDE0;
        y = 64'hDEAD_BEEF_0BAD_F00D;
        e = ref_mont(x, y, m);
        load_ops(x, y, m);
        for (int i = 0; i < K; i++) cmd(2'b01, '0);
        check(!busy, "R7 step keeps idle", K'(busy), '0);
        cmd(2'b00, '0);
        check(!done, "R8 resolve not yet done", K'(done), '0);
        @(negedge clk);
        check(done, "R8 resolve latency", K'(done), 64'd1);
        @(negedge clk);
        check(!done, "R5 done one cycle", K'(done), '0);
        unload(r);
        check(r == e, "R7 manual steps match", r, e);

        // directed corners
        run_mul(64'd0, 64'd12345, 64'd1000003, 0);
        run_mul(64'd1, 64'd1, 64'd3, 0);
        run_mul(64'd0, 64'd0, 64'd1, 0);
        run_mul(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        run_mul(64'hFFFF_FFFF_FFFF_FFFE, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0);

        // constrained random
        for (int t = 0; t < 24; t++) begin
            m = {$urandom, $urandom} | 64'd1;
            if (t % 3 == 0) m[K-1] = 1'b1;
            x = {$urandom, $urandom} % m;
            y = {$urandom, $urandom} % m;
            run_mul(x, y, m, (t % 4 == 1) ? 1 : ((t % 4 == 3) ? 2 : 0));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule